// File: doc/BRIEF.md
# High-Speed Burst Entry/Exit Sequencer

This block is the transmit-side control for a link with one forwarded clock lane and `NL` data lanes. It moves every lane out of the low-power stop state, through a request and bridge state, into high-speed drive. It then carries one payload burst and returns the lanes to the stop state in a fixed order. The clock lane starts high-speed operation first. It runs alone for a pre-overlap window before any data lane leaves low power, and it keeps running for a post-overlap window after the data lanes have gone back. One clock cycle is one UI, and every dwell time is a count of those cycles taken from a configuration input.

The payload arrives over a valid/ready stream, one bit per active lane per cycle. The first cycle in which `src_valid` is seen while idle starts a burst. Ready is raised only in the payload phase. Back-pressure works only one way. The block never stalls the source inside the payload phase. A source that drops `src_valid` there causes a stall cycle, in which every lane repeats its previous bit. The beat marked `src_last` ends the burst. Serialisation, analog drive and sync-word content are outside this block. The sync word appears only as a one-UI start marker.

Line codes are `{p,n}`: stop = 2'b11, request = 2'b01, bridge = 2'b00. All configuration inputs must be held stable while a burst is in progress.

Top module: `lane_burst_seq`

## Requirements
- R1: After reset and while idle, the clock lane and all data lanes show line code 2'b11, `*_hs_en` and `*_hs_bit` are 0, `src_ready` is 0 and `dl_sync` is 0.
- R2: A burst starts in the cycle after the idle state sees `src_valid`. The clock lane then shows 2'b01 for the effective LPX count, then 2'b00 for the clock-prepare count, then high-speed zero (`ck_hs_en`=1, bit 0) for the clock-zero count. After that it toggles every cycle, and the first toggling cycle drives 1.
- R3: The clock toggles for the effective clock-pre count, never fewer than 8 cycles, before any data lane leaves code 2'b11.
- R4: Each active data lane then shows 2'b01 for the LPX count and 2'b00 for the prepare count. Next it drives high-speed zero for the zero count, then one sync cycle with bit 1 and `dl_sync`=1, and then the payload.
- R5: `src_ready` is 1 only in the payload phase. An accepted beat drives `src_data[i]` on lane i in the same cycle. A payload cycle without `src_valid` repeats each lane's previous bit. The beat with `src_last` is the final one.
- R6: After the last beat, each active lane drives the inverse of its last payload bit for the trail count.
- R7: After the trail, the data lanes show 2'b11 while the clock keeps toggling for the clock-post count. The clock lane then drives high-speed zero for the clock-trail count, never fewer than 6 cycles.
- R8: All lanes then hold 2'b11 for the exit count, never fewer than 10 cycles. A request seen during that window does not start a burst. The block passes through one idle cycle before the next burst.
- R9: The LPX count is never shorter than 5 cycles. Any other count of 0 behaves as 1.
- R10: Only lanes 0 to L-1 take part, where L is `cfg_lanes`, with 0 treated as 1 and values above `NL` treated as `NL`. All other lanes stay at 2'b11 with high-speed drive off.
- R11: A lane in high-speed drive shows line code 2'b00. A lane not in high-speed drive has `hs_bit` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte/UI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lpx | input | CW | Low-power state length |
| cfg_clk_prep | input | CW | Clock lane bridge length |
| cfg_clk_zero | input | CW | Clock lane high-speed zero before toggling |
| cfg_clk_pre | input | CW | Clock toggling before data leaves low power |
| cfg_hs_prep | input | CW | Data lane bridge length |
| cfg_hs_zero | input | CW | Data lane high-speed zero before sync |
| cfg_trail | input | CW | Inverted trailer length |
| cfg_clk_post | input | CW | Clock toggling after data returns to low power |
| cfg_clk_trail | input | CW | Clock lane high-speed zero after toggling |
| cfg_exit | input | CW | Stop state length after a burst |
| cfg_lanes | input | LW | Number of active data lanes |
| src_valid | input | 1 | Payload beat valid / burst request |
| src_data | input | NL | One payload bit per lane |
| src_last | input | 1 | Marks the final beat |
| src_ready | output | 1 | Beat accepted this cycle when valid |
| ck_lp | output | 2 | Clock lane low-power line code |
| ck_hs_en | output | 1 | Clock lane high-speed drive |
| ck_hs_bit | output | 1 | Clock lane high-speed level |
| dl_lp | output | 2*NL | Data lane line codes, lane i at [2i+1:2i] |
| dl_hs_en | output | NL | Data lane high-speed drive |
| dl_hs_bit | output | NL | Data lane high-speed level |
| dl_sync | output | 1 | Sync start marker |

## Verification
Every lane output is decoded from the sequencer phase in the same cycle. A wrong phase therefore shows up on the lane codes in the first cycle it is held. A dwell count that is off by one moves the next line-code change by one cycle, and that cycle is the first mismatch. A wrong toggle phase or a lost last bit shows up on the clock level or the trailer in the cycle concerned. The reference model predicts every port value for every cycle, so any of these faults is reported at its first cycle.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CK_LP01, ST_CK_LP00, ST_CK_ZERO, ST_CK_PRE,
    ST_DL_LP01, ST_DL_LP00, ST_DL_ZERO, ST_SYNC, ST_PAYLOAD,
    ST_TRAIL, ST_CK_POST, ST_CK_TRAIL, ST_EXIT
  } seq_state_t;

  localparam logic [1:0] LINE_STOP   = 2'b11;
  localparam logic [1:0] LINE_REQ    = 2'b01;
  localparam logic [1:0] LINE_BRIDGE = 2'b00;
endpackage

// File: rtl/lbs_dwell_timer.sv
module lbs_dwell_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= len - 1'b1;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/lbs_clk_lane.sv
module lbs_clk_lane
  import lbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_t st,
  output logic [1:0] lp,
  output logic       hs_en,
  output logic       hs_bit
);
  logic running, ph_q;

  always_comb begin
    running = 1'b0;
    unique case (st)
      ST_CK_PRE, ST_DL_LP01, ST_DL_LP00, ST_DL_ZERO, ST_SYNC,
      ST_PAYLOAD, ST_TRAIL, ST_CK_POST: running = 1'b1;
      default: running = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= running ? ~ph_q : 1'b0;
  end

  always_comb begin
    lp = LINE_STOP;
    hs_en = 1'b0;
    if (st == ST_CK_LP01)      lp = LINE_REQ;
    else if (st == ST_CK_LP00) lp = LINE_BRIDGE;
    else if (running || st == ST_CK_ZERO || st == ST_CK_TRAIL) begin
      lp = LINE_BRIDGE;
      hs_en = 1'b1;
    end
    hs_bit = running & ~ph_q;
  end
endmodule

// File: rtl/lbs_data_lane.sv
module lbs_data_lane
  import lbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_t st,
  input  logic       active,
  input  logic       src_bit,
  input  logic       src_valid,
  output logic [1:0] lp,
  output logic       hs_en,
  output logic       hs_bit
);
  logic last_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                              last_q <= 1'b0;
    else if (st == ST_SYNC)                  last_q <= 1'b1;
    else if (st == ST_PAYLOAD && src_valid)  last_q <= src_bit;
  end

  always_comb begin
    lp = LINE_STOP;
    hs_en = 1'b0;
    hs_bit = 1'b0;
    if (active) begin
      unique case (st)
        ST_DL_LP01: lp = LINE_REQ;
        ST_DL_LP00: lp = LINE_BRIDGE;
        ST_DL_ZERO: begin lp = LINE_BRIDGE; hs_en = 1'b1; end
        ST_SYNC:    begin lp = LINE_BRIDGE; hs_en = 1'b1; hs_bit = 1'b1; end
        ST_PAYLOAD: begin
          lp = LINE_BRIDGE; hs_en = 1'b1;
          hs_bit = src_valid ? src_bit : last_q;
        end
        ST_TRAIL:   begin lp = LINE_BRIDGE; hs_en = 1'b1; hs_bit = ~last_q; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lane_burst_seq.sv
module lane_burst_seq
  import lbs_pkg::*;
#(
  parameter int NL            = 4,
  parameter int CW            = 8,
  parameter int MIN_LPX       = 5,
  parameter int MIN_CLK_PRE   = 8,
  parameter int MIN_CLK_TRAIL = 6,
  parameter int MIN_EXIT      = 10,
  localparam int LW = $clog2(NL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   cfg_lpx,
  input  logic [CW-1:0]   cfg_clk_prep,
  input  logic [CW-1:0]   cfg_clk_zero,
  input  logic [CW-1:0]   cfg_clk_pre,
  input  logic [CW-1:0]   cfg_hs_prep,
  input  logic [CW-1:0]   cfg_hs_zero,
  input  logic [CW-1:0]   cfg_trail,
  input  logic [CW-1:0]   cfg_clk_post,
  input  logic [CW-1:0]   cfg_clk_trail,
  input  logic [CW-1:0]   cfg_exit,
  input  logic [LW-1:0]   cfg_lanes,
  input  logic            src_valid,
  input  logic [NL-1:0]   src_data,
  input  logic            src_last,
  output logic            src_ready,
  output logic [1:0]      ck_lp,
  output logic            ck_hs_en,
  output logic            ck_hs_bit,
  output logic [2*NL-1:0] dl_lp,
  output logic [NL-1:0]   dl_hs_en,
  output logic [NL-1:0]   dl_hs_bit,
  output logic            dl_sync
);
  seq_state_t st_q, st_d;
  logic       done;
  logic [CW-1:0] len_d;
  logic [LW-1:0] eff_lanes;

  function automatic logic [CW-1:0] floor_at(input logic [CW-1:0] v, input int mn);
    return (int'(v) < mn) ? CW'(mn) : v;
  endfunction

  // R10: clamp the lane count into 1..NL
  always_comb begin
    if (cfg_lanes == '0)          eff_lanes = LW'(1);
    else if (int'(cfg_lanes) > NL) eff_lanes = LW'(NL);
    else                           eff_lanes = cfg_lanes;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (src_valid) st_d = ST_CK_LP01;
      ST_CK_LP01:  if (done) st_d = ST_CK_LP00;
      ST_CK_LP00:  if (done) st_d = ST_CK_ZERO;
      ST_CK_ZERO:  if (done) st_d = ST_CK_PRE;
      ST_CK_PRE:   if (done) st_d = ST_DL_LP01;
      ST_DL_LP01:  if (done) st_d = ST_DL_LP00;
      ST_DL_LP00:  if (done) st_d = ST_DL_ZERO;
      ST_DL_ZERO:  if (done) st_d = ST_SYNC;
      ST_SYNC:     if (done) st_d = ST_PAYLOAD;
      ST_PAYLOAD:  if (src_valid && src_last) st_d = ST_TRAIL;
      ST_TRAIL:    if (done) st_d = ST_CK_POST;
      ST_CK_POST:  if (done) st_d = ST_CK_TRAIL;
      ST_CK_TRAIL: if (done) st_d = ST_EXIT;
      ST_EXIT:     if (done) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_d)
      ST_CK_LP01, ST_DL_LP01: len_d = floor_at(cfg_lpx, MIN_LPX);
      ST_CK_LP00:  len_d = floor_at(cfg_clk_prep, 1);
      ST_CK_ZERO:  len_d = floor_at(cfg_clk_zero, 1);
      ST_CK_PRE:   len_d = floor_at(cfg_clk_pre, MIN_CLK_PRE);
      ST_DL_LP00:  len_d = floor_at(cfg_hs_prep, 1);
      ST_DL_ZERO:  len_d = floor_at(cfg_hs_zero, 1);
      ST_TRAIL:    len_d = floor_at(cfg_trail, 1);
      ST_CK_POST:  len_d = floor_at(cfg_clk_post, 1);
      ST_CK_TRAIL: len_d = floor_at(cfg_clk_trail, MIN_CLK_TRAIL);
      ST_EXIT:     len_d = floor_at(cfg_exit, MIN_EXIT);
      default:     len_d = CW'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  lbs_dwell_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(st_d != st_q), .len(len_d), .done(done)
  );

  lbs_clk_lane u_ck (
    .clk(clk), .rst_n(rst_n), .st(st_q),
    .lp(ck_lp), .hs_en(ck_hs_en), .hs_bit(ck_hs_bit)
  );

  for (genvar i = 0; i < NL; i++) begin : g_lane
    lbs_data_lane u_dl (
      .clk(clk), .rst_n(rst_n), .st(st_q),
      .active(i < int'(eff_lanes)),
      .src_bit(src_data[i]), .src_valid(src_valid),
      .lp(dl_lp[2*i +: 2]), .hs_en(dl_hs_en[i]), .hs_bit(dl_hs_bit[i])
    );
  end

  assign src_ready = (st_q == ST_PAYLOAD);
  assign dl_sync   = (st_q == ST_SYNC);
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
  parameter int NL = 4,
  parameter int LW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [LW-1:0]   cfg_lanes,
  input logic            src_valid,
  input logic            src_ready,
  input logic            src_last,
  input logic [NL-1:0]   src_data,
  input logic [1:0]      ck_lp,
  input logic            ck_hs_en,
  input logic [2*NL-1:0] dl_lp,
  input logic [NL-1:0]   dl_hs_en,
  input logic [NL-1:0]   dl_hs_bit
);
  p_ready_in_hs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (ck_hs_en && dl_hs_en[0] && dl_lp[1:0] == 2'b00));

  p_clock_leads_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_lp[1:0] != 2'b11) |-> ck_hs_en);

  p_trail_inverse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_ready && src_last) |=>
      (dl_hs_en[0] && (dl_hs_bit[0] == !$past(src_data[0]))));

  p_req_then_bridge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ck_lp) == 2'b01 && ck_lp != 2'b01) |-> (ck_lp == 2'b00 && !ck_hs_en));

  p_hs_line_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dl_hs_en[0] |-> (dl_lp[1:0] == 2'b00));

  for (genvar i = 1; i < NL; i++) begin : g_idle
    p_unused_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cfg_lanes) <= i) |-> (dl_lp[2*i +: 2] == 2'b11 && !dl_hs_en[i]));
  end
endmodule

bind lane_burst_seq lbs_checker #(.NL(NL), .LW(LW)) u_lbs_checker (
  .clk(clk), .rst_n(rst_n), .cfg_lanes(cfg_lanes),
  .src_valid(src_valid), .src_ready(src_ready), .src_last(src_last),
  .src_data(src_data), .ck_lp(ck_lp), .ck_hs_en(ck_hs_en),
  .dl_lp(dl_lp), .dl_hs_en(dl_hs_en), .dl_hs_bit(dl_hs_bit)
);

// File: tb/test_lane_burst_seq.sv
module test_lane_burst_seq;
  localparam int NL = 4, CW = 8, LW = 3;
  localparam int VW = 2 + 1 + 1 + 2*NL + NL + NL + 1 + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] c_lpx, c_cprep, c_czero, c_cpre, c_hprep, c_hzero,
                 c_trail, c_cpost, c_ctrail, c_exit;
  logic [LW-1:0] c_lanes;
  logic src_valid = 1'b0, src_last = 1'b0;
  logic [NL-1:0] src_data = '0;
  logic src_ready, ck_hs_en, ck_hs_bit, dl_sync;
  logic [1:0] ck_lp;
  logic [2*NL-1:0] dl_lp;
  logic [NL-1:0] dl_hs_en, dl_hs_bit;

  int checks = 0, errors = 0, tog = 0, exp_lanes = 4, bid = 0;
  bit finished = 0;
  logic [VW-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  lane_burst_seq #(.NL(NL), .CW(CW)) i_lane_burst_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_lpx(c_lpx), .cfg_clk_prep(c_cprep), .cfg_clk_zero(c_czero),
    .cfg_clk_pre(c_cpre), .cfg_hs_prep(c_hprep), .cfg_hs_zero(c_hzero),
    .cfg_trail(c_trail), .cfg_clk_post(c_cpost), .cfg_clk_trail(c_ctrail),
    .cfg_exit(c_exit), .cfg_lanes(c_lanes),
    .src_valid(src_valid), .src_data(src_data), .src_last(src_last),
    .src_ready(src_ready), .ck_lp(ck_lp), .ck_hs_en(ck_hs_en),
    .ck_hs_bit(ck_hs_bit), .dl_lp(dl_lp), .dl_hs_en(dl_hs_en),
    .dl_hs_bit(dl_hs_bit), .dl_sync(dl_sync)
  );

  function automatic int eff(input int v, input int mn);
    return (v < mn) ? mn : v;
  endfunction

  function automatic logic [NL-1:0] dat(input int b, input int k);
    return NL'(b*5 + k*3 + (k >> 1) + b*k);
  endfunction

  // ckm: 0 stop, 1 request, 2 bridge, 3 hs zero, 4 toggling
  // dm : 0 stop, 1 request, 2 bridge, 3 hs with bits
  task automatic push(input int ckm, input int dm, input logic [NL-1:0] bits,
                      input logic rdy, input logic sy, input string tg);
    logic [1:0] cl; logic ce, cb;
    logic [2*NL-1:0] dlp; logic [NL-1:0] de, db;
    cl = 2'b11; ce = 0; cb = 0;
    case (ckm)
      1: cl = 2'b01;
      2: cl = 2'b00;
      3: begin cl = 2'b00; ce = 1; end
      4: begin cl = 2'b00; ce = 1; cb = (tog % 2 == 0); tog++; end
      default: ;
    endcase
    for (int i = 0; i < NL; i++) begin
      dlp[2*i +: 2] = 2'b11; de[i] = 0; db[i] = 0;
      if (i < exp_lanes) begin
        case (dm)
          1: dlp[2*i +: 2] = 2'b01;
          2: dlp[2*i +: 2] = 2'b00;
          3: begin dlp[2*i +: 2] = 2'b00; de[i] = 1; db[i] = bits[i]; end
          default: ;
        endcase
      end
    end
    exp_q.push_back({cl, ce, cb, dlp, de, db, rdy, sy});
    tag_q.push_back(tg);
  endtask

  function automatic logic [VW-1:0] actual();
    return {ck_lp, ck_hs_en, ck_hs_bit, dl_lp, dl_hs_en, dl_hs_bit, src_ready, dl_sync};
  endfunction

  task automatic compare(input logic [VW-1:0] e, input string tg);
    checks++;
    if (actual() !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tg, actual(), e, $time);
    end
  endtask

  task automatic idle_check(input int m, input string tg);
    for (int j = 0; j < m; j++) begin
      @(negedge clk);
      compare({2'b11, 1'b0, 1'b0, {NL{2'b11}}, {NL{1'b0}}, {NL{1'b0}}, 1'b0, 1'b0}, tg);
    end
  endtask

  task automatic build(input int n, input int stall_at);
    push(0, 0, '0, 0, 0, "R8 one idle cycle before start");
    tog = 0;
    repeat (eff(int'(c_lpx), 5))   push(1, 0, '0, 0, 0, "R2/R9 clock LP-01 for LPX");
    repeat (eff(int'(c_cprep), 1)) push(2, 0, '0, 0, 0, "R2 clock LP-00 prepare");
    repeat (eff(int'(c_czero), 1)) push(3, 0, '0, 0, 0, "R2 clock HS-0 zero");
    repeat (eff(int'(c_cpre), 8))  push(4, 0, '0, 0, 0, "R3 clock pre window");
    repeat (eff(int'(c_lpx), 5))   push(4, 1, '0, 0, 0, "R4/R9 data LP-01 for LPX");
    repeat (eff(int'(c_hprep), 1)) push(4, 2, '0, 0, 0, "R4 data LP-00 prepare");
    repeat (eff(int'(c_hzero), 1)) push(4, 3, '0, 0, 0, "R4/R11 data HS-0 zero");
    push(4, 3, '1, 0, 1, "R4 sync marker");
    for (int k = 0; k < n; k++) begin
      push(4, 3, dat(bid, k), 1, 0, "R5 payload beat");
      if (stall_at != 0 && k == stall_at - 1)
        push(4, 3, dat(bid, k), 1, 0, "R5 stall repeats bit");
    end
    repeat (eff(int'(c_trail), 1))  push(4, 3, ~dat(bid, n-1), 0, 0, "R6 inverted trailer");
    repeat (eff(int'(c_cpost), 1))  push(4, 0, '0, 0, 0, "R7 clock post window");
    repeat (eff(int'(c_ctrail), 6)) push(3, 0, '0, 0, 0, "R7 clock trail");
    repeat (eff(int'(c_exit), 10))  push(0, 0, '0, 0, 0, "R8 exit stop state");
  endtask

  task automatic burst(input int n, input int stall_at, input bit b2b,
                       input int next_n, input bit cont);
    int k = 0;
    bit acc, stalled = 0;
    build(n, stall_at);
    if (!cont) begin
      @(posedge clk); #1;
      src_valid = 1; src_data = dat(bid, 0); src_last = (n == 1);
    end
    while (exp_q.size() > 0) begin
      @(negedge clk);
      compare(exp_q.pop_front(), tag_q.pop_front());
      acc = src_valid && src_ready;
      @(posedge clk); #1;
      if (acc) begin
        k++;
        if (k == n) begin
          if (b2b) begin
            src_data = dat(bid + 1, 0); src_last = (next_n == 1);
          end else begin
            src_valid = 0; src_last = 0;
          end
        end else if (stall_at != 0 && k == stall_at && !stalled) begin
          src_valid = 0; stalled = 1;
        end else begin
          src_data = dat(bid, k); src_last = (k == n - 1);
        end
      end else if (stalled && !src_valid && k < n) begin
        src_valid = 1; src_data = dat(bid, k); src_last = (k == n - 1);
      end
    end
    bid++;
  endtask

  task automatic set_cfg(input int lpx, cp, cz, cpr, hp, hz, tr, cpo, ctr, ex, ln);
    c_lpx = CW'(lpx); c_cprep = CW'(cp); c_czero = CW'(cz); c_cpre = CW'(cpr);
    c_hprep = CW'(hp); c_hzero = CW'(hz); c_trail = CW'(tr); c_cpost = CW'(cpo);
    c_ctrail = CW'(ctr); c_exit = CW'(ex); c_lanes = LW'(ln);
    exp_lanes = (ln == 0) ? 1 : ((ln > NL) ? NL : ln);
  endtask

  initial begin
    set_cfg(6, 4, 7, 9, 5, 6, 8, 7, 6, 12, 4);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle_check(3, "R1 reset state");

    burst(5, 0, 0, 0, 0);                 // all lanes, default counts
    idle_check(4, "R1 idle after burst");

    set_cfg(7, 2, 3, 11, 3, 4, 3, 9, 8, 15, 2);
    burst(3, 0, 0, 0, 0);                 // R10: two lanes
    idle_check(2, "R10 idle two lanes");

    set_cfg(2, 0, 0, 3, 0, 0, 0, 0, 1, 4, 0);
    burst(1, 0, 0, 0, 0);                 // R9/R10: floors and lane count 0
    idle_check(2, "R9 idle after minimum burst");

    set_cfg(5, 3, 2, 8, 2, 3, 2, 4, 6, 10, 7);
    burst(4, 0, 1, 6, 0);                 // R8: request held through exit
    burst(6, 2, 0, 0, 1);                 // R5: stall inside payload
    idle_check(3, "R1 final idle");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule